// File: doc/BRIEF.md
# CCD Sensor Timing Generator

This block produces the digital drive timing for a progressive-scan interline CCD. Two free-running counters step through the sensor frame: a pixel counter inside each line and a line counter inside each frame. Every drive signal is decoded from them. The signals are:

- the line and frame sync marks;
- the two-phase horizontal shift clocks and the reset gate;
- the three-phase vertical shift enables;
- the long readout pulse that moves photodiode charge into the vertical registers;
- the substrate drain request used as the electronic shutter;
- a two-bit tag on each pixel that classifies it as dummy, optically black or effective.

A level-shifting driver stage turns these logic-level enables into the voltages the sensor needs.

Each pixel takes four clocks of the block clock. This gives the horizontal clocks and the reset gate sub-pixel edges without a second clock domain. A mode input chooses normal readout or double-speed readout. Double-speed readout sums two rows in every line and so halves the number of lines in a frame. A shutter input chooses how long the sensor drains charge after the sync frame. Both settings are taken up only where a frame starts.

Top module: `ccd_timing_gen`

## Requirements
- R1: A line lasts LINE_PIX pixels, and each pixel lasts four clocks, numbered subphase 0 to 3. `hd` is high during pixels 0 to HD_PIX-1 of every line.
- R2: A frame lasts LINES_NORM lines when the latched mode is 0 and LINES_DBL lines when it is 1. `vd` is high for the whole of line 0 and low on every other line.
- R3: `dbl_mode` and `shut_line` are sampled only in a reset cycle and on the last clock of a frame. A change made in the middle of a frame leaves that frame's length, shutter and vertical pattern untouched.
- R4: Inside the serial window, `h1` is high in subphases 0 and 1 and `h2` is high in subphases 2 and 3. `rg` is high only in subphase 0. Outside the window the clocks are parked at `h1`=0, `h2`=1, `rg`=0.
- R5: The serial window is the last H_DUMMY+H_OB_LEAD+H_EFF+H_OB_TRAIL pixels of a line, and it is open only on data lines. The row of line v (v>0) is v-1 in normal mode and 2(v-1) in double mode. A line is a data line when its row is below the total row count V_DUMMY+V_OB_LEAD+V_EFF+V_OB_TRAIL.
- R6: `pix_region` uses the encoding 0 = no pixel, 1 = dummy, 2 = optical black, 3 = effective. Within the window, the first H_DUMMY pixels are dummy, the next H_OB_LEAD are black, the next H_EFF are effective when the row is effective, and the remaining H_OB_TRAIL are black.
- R7: The rows are ordered as V_DUMMY dummy rows, then V_OB_LEAD black rows, then V_EFF effective rows, then V_OB_TRAIL black rows. A dummy row tags its whole window 1. A black row tags as 2 every pixel that is not dummy.
- R8: Off line 0, the vertical enables `{v1,v2,v3}` take the step sequence 110, 010, 011, 001, 101, 100 from pixel VT_START onward, VT_STEP pixels per step. The sequence runs once per line in normal mode and twice in double mode. Outside the sequence the enables rest at 100.
- R9: On line 0, `{v1,v2,v3}` is 010 for SG_PRE+SG_LEN+SG_POST pixels starting at SG_START. `sg` is high only during the middle SG_LEN pixels of that span, and `sg` is never high on any other line.
- R10: `sub_pulse` is high for SUB_PIX pixels starting at pixel SUB_START on lines 1 to S-1, where S is the latched shutter value. When S is 0 or 1 there is no pulse.
- R11: A reset cycle restarts the frame. On the first clock after it the block is at line 0, pixel 0, subphase 0, so `vd`=1 and `hd`=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock, four per pixel |
| rst | input | 1 | Synchronous active-high reset |
| dbl_mode | input | 1 | 1 selects double-speed readout |
| shut_line | input | LW | First line after sync without substrate drain; 0 disables |
| hd | output | 1 | Line sync |
| vd | output | 1 | Frame sync |
| h1 | output | 1 | Horizontal shift clock phase 1 |
| h2 | output | 1 | Horizontal shift clock phase 2 |
| rg | output | 1 | Reset gate pulse |
| v1 | output | 1 | Vertical shift enable phase 1 |
| v2 | output | 1 | Vertical shift enable phase 2 |
| v3 | output | 1 | Vertical shift enable phase 3 |
| sg | output | 1 | Sensor readout pulse |
| sub_pulse | output | 1 | Substrate drain request |
| pix_region | output | 2 | Pixel class tag |

## Verification
Every output is decoded without further registers from the counter state. The output belonging to a counter position is therefore valid in the same clock that follows the edge which set that position. The bench advances a behavioural position model at each rising edge and compares all outputs at the falling edge after it.

Mode and shutter changes count as due at the first clock of the next frame, never earlier. The bench changes them in the middle of a frame and measures the cycles between sync rises to confirm that the current frame kept its length. A reset is due one edge later: the falling-edge sample after the reset edge must show line 0, pixel 0.

// File: rtl/ccdtg_pkg.sv
package ccdtg_pkg;

    typedef enum logic [1:0] {
        RGN_NONE  = 2'd0,
        RGN_DUMMY = 2'd1,
        RGN_BLACK = 2'd2,
        RGN_EFF   = 2'd3
    } region_e;

    typedef struct packed {
        logic p1;
        logic p2;
        logic p3;
    } vphase_t;

    localparam int      VT_STEPS = 6;
    localparam vphase_t VP_REST  = vphase_t'(3'b100);
    localparam vphase_t VP_HOLD  = vphase_t'(3'b010);

    function automatic vphase_t vt_step(input int idx);
        case (idx)
            0:       return vphase_t'(3'b110);
            1:       return vphase_t'(3'b010);
            2:       return vphase_t'(3'b011);
            3:       return vphase_t'(3'b001);
            4:       return vphase_t'(3'b101);
            default: return VP_REST;
        endcase
    endfunction

endpackage

// File: rtl/ccdtg_counters.sv
module ccdtg_counters #(
    parameter int LINE_PIX   = 1616,
    parameter int LINES_NORM = 1044,
    parameter int LINES_DBL  = 522,
    parameter int HW         = 11,
    parameter int LW         = 11
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          dbl_in,
    input  logic [LW-1:0] shut_in,
    output logic [1:0]    sub_o,
    output logic [HW-1:0] pix_o,
    output logic [LW-1:0] line_o,
    output logic          dbl_o,
    output logic [LW-1:0] shut_o
);
    logic [LW-1:0] last_line;
    logic          pix_last;
    logic          line_last;

    always_comb begin
        last_line = dbl_o ? LW'(LINES_DBL - 1) : LW'(LINES_NORM - 1);
        pix_last  = (sub_o == 2'd3) && (pix_o == HW'(LINE_PIX - 1));
        line_last = pix_last && (line_o == last_line);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sub_o  <= 2'd0;
            pix_o  <= '0;
            line_o <= '0;
            dbl_o  <= dbl_in;
            shut_o <= shut_in;
        end else begin
            sub_o <= sub_o + 2'd1;
            if (sub_o == 2'd3) begin
                pix_o <= pix_last ? '0 : pix_o + HW'(1);
            end
            if (pix_last) begin
                line_o <= line_last ? '0 : line_o + LW'(1);
            end
            if (line_last) begin
                dbl_o  <= dbl_in;
                shut_o <= shut_in;
            end
        end
    end
endmodule

// File: rtl/ccdtg_hgen.sv
module ccdtg_hgen
    import ccdtg_pkg::*;
#(
    parameter int LINE_PIX   = 1616,
    parameter int HD_PIX     = 16,
    parameter int H_DUMMY    = 24,
    parameter int H_OB_LEAD  = 4,
    parameter int H_EFF      = 1300,
    parameter int H_OB_TRAIL = 56,
    parameter int V_DUMMY    = 1,
    parameter int V_OB_LEAD  = 3,
    parameter int V_EFF      = 1030,
    parameter int V_OB_TRAIL = 1,
    parameter int HW         = 11,
    parameter int LW         = 11
) (
    input  logic [1:0]    sub,
    input  logic [HW-1:0] pix,
    input  logic [LW-1:0] line,
    input  logic          dbl,
    output logic          hd,
    output logic          h1,
    output logic          h2,
    output logic          rg,
    output region_e       region
);
    localparam int WIN_LEN   = H_DUMMY + H_OB_LEAD + H_EFF + H_OB_TRAIL;
    localparam int WIN_START = LINE_PIX - WIN_LEN;
    localparam int ROWS      = V_DUMMY + V_OB_LEAD + V_EFF + V_OB_TRAIL;
    localparam int EFF_ROW0  = V_DUMMY + V_OB_LEAD;
    localparam int EFF_COL0  = H_DUMMY + H_OB_LEAD;

    int   hi, vi, row, pos;
    logic active, row_dummy, row_eff, col_dummy, col_eff;

    always_comb begin
        hi        = int'(pix);
        vi        = int'(line);
        row       = dbl ? 2 * (vi - 1) : vi - 1;
        pos       = hi - WIN_START;
        active    = (vi != 0) && (row < ROWS) && (hi >= WIN_START);
        row_dummy = row < V_DUMMY;
        row_eff   = (row >= EFF_ROW0) && (row < EFF_ROW0 + V_EFF);
        col_dummy = pos < H_DUMMY;
        col_eff   = (pos >= EFF_COL0) && (pos < EFF_COL0 + H_EFF);
        if (!active)                    region = RGN_NONE;
        else if (row_dummy || col_dummy) region = RGN_DUMMY;
        else if (row_eff && col_eff)    region = RGN_EFF;
        else                            region = RGN_BLACK;
        h1 = active && !sub[1];
        h2 = !active || sub[1];
        rg = active && (sub == 2'd0);
        hd = hi < HD_PIX;
    end
endmodule

// File: rtl/ccdtg_vgen.sv
module ccdtg_vgen
    import ccdtg_pkg::*;
#(
    parameter int VT_START  = 24,
    parameter int VT_STEP   = 16,
    parameter int SG_START  = 40,
    parameter int SG_PRE    = 81,
    parameter int SG_LEN    = 683,
    parameter int SG_POST   = 102,
    parameter int SUB_START = 200,
    parameter int SUB_PIX   = 8,
    parameter int HW        = 11,
    parameter int LW        = 11
) (
    input  logic [HW-1:0] pix,
    input  logic [LW-1:0] line,
    input  logic          dbl,
    input  logic [LW-1:0] shut,
    output logic          vd,
    output vphase_t       vph,
    output logic          sg,
    output logic          sub_pulse
);
    localparam int SG_END = SG_START + SG_PRE + SG_LEN + SG_POST;
    localparam int CORE0  = SG_START + SG_PRE;
    localparam int CORE1  = CORE0 + SG_LEN;
    localparam int VT_ONE = VT_STEPS * VT_STEP;

    int   hi, vi, rel, step_num;
    logic in_vt;

    always_comb rel = int'(pix) - VT_START;

    generate
        if (VT_STEP == 1) begin : g_unit_step
            always_comb step_num = rel;
        end else begin : g_div_step
            always_comb step_num = rel / VT_STEP;
        end
    endgenerate

    always_comb begin
        hi    = int'(pix);
        vi    = int'(line);
        vd    = (vi == 0);
        in_vt = (rel >= 0) && (rel < (dbl ? 2 * VT_ONE : VT_ONE));
        sg    = vd && (hi >= CORE0) && (hi < CORE1);
        if (vd)         vph = ((hi >= SG_START) && (hi < SG_END)) ? VP_HOLD : VP_REST;
        else if (in_vt) vph = vt_step(step_num % VT_STEPS);
        else            vph = VP_REST;
        sub_pulse = !vd && (vi < int'(shut))
                    && (hi >= SUB_START) && (hi < SUB_START + SUB_PIX);
    end
endmodule

// File: rtl/ccd_timing_gen.sv
module ccd_timing_gen
    import ccdtg_pkg::*;
#(
    parameter int LINE_PIX   = 1616,
    parameter int LINES_NORM = 1044,
    parameter int LINES_DBL  = 522,
    parameter int HD_PIX     = 16,
    parameter int H_DUMMY    = 24,
    parameter int H_OB_LEAD  = 4,
    parameter int H_EFF      = 1300,
    parameter int H_OB_TRAIL = 56,
    parameter int V_DUMMY    = 1,
    parameter int V_OB_LEAD  = 3,
    parameter int V_EFF      = 1030,
    parameter int V_OB_TRAIL = 1,
    parameter int VT_START   = 24,
    parameter int VT_STEP    = 16,
    parameter int SG_START   = 40,
    parameter int SG_PRE     = 81,
    parameter int SG_LEN     = 683,
    parameter int SG_POST    = 102,
    parameter int SUB_START  = 200,
    parameter int SUB_PIX    = 8,
    localparam int HW        = $clog2(LINE_PIX),
    localparam int LW        = $clog2(LINES_NORM + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          dbl_mode,
    input  logic [LW-1:0] shut_line,
    output logic          hd,
    output logic          vd,
    output logic          h1,
    output logic          h2,
    output logic          rg,
    output logic          v1,
    output logic          v2,
    output logic          v3,
    output logic          sg,
    output logic          sub_pulse,
    output logic [1:0]    pix_region
);
    logic [1:0]    sub_q;
    logic [HW-1:0] pix_q;
    logic [LW-1:0] line_q;
    logic          dbl_q;
    logic [LW-1:0] shut_q;
    region_e       region;
    vphase_t       vph;

    ccdtg_counters #(
        .LINE_PIX(LINE_PIX), .LINES_NORM(LINES_NORM), .LINES_DBL(LINES_DBL),
        .HW(HW), .LW(LW)
    ) u_cnt (
        .clk(clk), .rst(rst), .dbl_in(dbl_mode), .shut_in(shut_line),
        .sub_o(sub_q), .pix_o(pix_q), .line_o(line_q),
        .dbl_o(dbl_q), .shut_o(shut_q)
    );

    ccdtg_hgen #(
        .LINE_PIX(LINE_PIX), .HD_PIX(HD_PIX),
        .H_DUMMY(H_DUMMY), .H_OB_LEAD(H_OB_LEAD), .H_EFF(H_EFF), .H_OB_TRAIL(H_OB_TRAIL),
        .V_DUMMY(V_DUMMY), .V_OB_LEAD(V_OB_LEAD), .V_EFF(V_EFF), .V_OB_TRAIL(V_OB_TRAIL),
        .HW(HW), .LW(LW)
    ) u_hgen (
        .sub(sub_q), .pix(pix_q), .line(line_q), .dbl(dbl_q),
        .hd(hd), .h1(h1), .h2(h2), .rg(rg), .region(region)
    );

    ccdtg_vgen #(
        .VT_START(VT_START), .VT_STEP(VT_STEP),
        .SG_START(SG_START), .SG_PRE(SG_PRE), .SG_LEN(SG_LEN), .SG_POST(SG_POST),
        .SUB_START(SUB_START), .SUB_PIX(SUB_PIX), .HW(HW), .LW(LW)
    ) u_vgen (
        .pix(pix_q), .line(line_q), .dbl(dbl_q), .shut(shut_q),
        .vd(vd), .vph(vph), .sg(sg), .sub_pulse(sub_pulse)
    );

    assign v1         = vph.p1;
    assign v2         = vph.p2;
    assign v3         = vph.p3;
    assign pix_region = region;
endmodule

// File: rtl/ccdtg_checker.sv
module ccdtg_checker (
    input logic       clk,
    input logic       rst,
    input logic       hd,
    input logic       vd,
    input logic       h1,
    input logic       h2,
    input logic       rg,
    input logic       v1,
    input logic       v2,
    input logic       v3,
    input logic       sg,
    input logic       sub_pulse,
    input logic [1:0] pix_region
);
    // reset gate only inside the first half of a pixel, with phase 2 low
    assert_rg_in_h1_R4: assert property (@(posedge clk) disable iff (rst)
        rg |-> (h1 && !h2));

    // vertical enables never all high and never all low
    assert_vphase_legal_R8: assert property (@(posedge clk) disable iff (rst)
        !(v1 && v2 && v3) && (v1 || v2 || v3));

    // readout pulse only on the sync line, under phase 2 alone
    assert_sg_under_v2_R9: assert property (@(posedge clk) disable iff (rst)
        sg |-> (vd && v2 && !v1 && !v3));

    // drain request only in blanking and never on the sync line
    assert_sub_in_blank_R10: assert property (@(posedge clk) disable iff (rst)
        sub_pulse |-> (pix_region == 2'd0) && !vd);

    // no tagged pixel during line sync or on the sync line
    assert_region_off_sync_R6: assert property (@(posedge clk) disable iff (rst)
        (pix_region != 2'd0) |-> (!hd && !vd));

    // line sync lasts at least one full pixel
    assert_hd_min_width_R1: assert property (@(posedge clk) disable iff (rst)
        $rose(hd) |=> hd);
endmodule

bind ccd_timing_gen ccdtg_checker u_chk (.*);

// File: tb/tb_ccd_timing_gen.sv
module tb_ccd_timing_gen;
    localparam int LP = 40, LN = 14, LD = 7, HDP = 2;
    localparam int HDUM = 2, HOBL = 1, HEFF = 20, HOBT = 3;
    localparam int VDUM = 1, VOBL = 2, VEFF = 6, VOBT = 1;
    localparam int VTS = 2, VST = 1, SGS = 1, SGP = 3, SGL = 20, SGQ = 4;
    localparam int SUBS = 10, SUBP = 2;
    localparam int LW = $clog2(LN + 1);
    localparam int WIN_S = LP - (HDUM + HOBL + HEFF + HOBT);
    localparam int ROWS = VDUM + VOBL + VEFF + VOBT;
    localparam logic [2:0] PAT [6] = '{3'b110, 3'b010, 3'b011, 3'b001, 3'b101, 3'b100};

    logic clk = 1'b0, rst = 1'b1, dbl_mode = 1'b0;
    logic [LW-1:0] shut_line = '0;
    logic hd, vd, h1, h2, rg, v1, v2, v3, sg, sub_pulse;
    logic [1:0] pix_region;

    int n_chk = 0, n_bad = 0, cyc = 0;
    int m_sub, m_h, m_v, m_shut;
    bit m_dbl, m_ok = 0, done = 0;

    always #2 clk = ~clk;

    ccd_timing_gen #(
        .LINE_PIX(LP), .LINES_NORM(LN), .LINES_DBL(LD), .HD_PIX(HDP),
        .H_DUMMY(HDUM), .H_OB_LEAD(HOBL), .H_EFF(HEFF), .H_OB_TRAIL(HOBT),
        .V_DUMMY(VDUM), .V_OB_LEAD(VOBL), .V_EFF(VEFF), .V_OB_TRAIL(VOBT),
        .VT_START(VTS), .VT_STEP(VST), .SG_START(SGS), .SG_PRE(SGP), .SG_LEN(SGL),
        .SG_POST(SGQ), .SUB_START(SUBS), .SUB_PIX(SUBP)
    ) dut (.*);

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
        end
    endtask

    function automatic int exp_region(int h, int v, bit d);
        int row, pos;
        if (v == 0) return 0;
        row = d ? 2 * (v - 1) : v - 1;
        if (row >= ROWS || h < WIN_S) return 0;
        pos = h - WIN_S;
        if (row < VDUM || pos < HDUM) return 1;
        if (row >= VDUM + VOBL && row < VDUM + VOBL + VEFF &&
            pos >= HDUM + HOBL && pos < HDUM + HOBL + HEFF) return 3;
        return 2;
    endfunction

    function automatic int exp_vph(int h, int v, bit d);
        int n;
        if (v == 0) return (h >= SGS && h < SGS + SGP + SGL + SGQ) ? 3'b010 : 3'b100;
        n = d ? 12 : 6;
        if (h >= VTS && h < VTS + n * VST) return int'(PAT[((h - VTS) / VST) % 6]);
        return 3'b100;
    endfunction

    // position model, advanced at every rising edge
    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            m_sub = 0; m_h = 0; m_v = 0; m_dbl = dbl_mode; m_shut = int'(shut_line); m_ok = 1;
        end else if (m_ok) begin
            if (m_sub < 3) m_sub++;
            else begin
                m_sub = 0;
                if (m_h < LP - 1) m_h++;
                else begin
                    m_h = 0;
                    if (m_v < (m_dbl ? LD : LN) - 1) m_v++;
                    else begin m_v = 0; m_dbl = dbl_mode; m_shut = int'(shut_line); end
                end
            end
        end
    end

    // compare at the falling edge
    always @(negedge clk) begin
        if (m_ok && !done) begin
            int reg_e, act;
            reg_e = exp_region(m_h, m_v, m_dbl);
            act = reg_e != 0;
            check("R1 hd", int'(hd), int'(m_h < HDP));
            check("R2 vd", int'(vd), int'(m_v == 0));
            check("R4 R5 hclk", int'({h1, h2, rg}),
                  int'({act && m_sub < 2, !act || m_sub >= 2, act && m_sub == 0}));
            check("R6 R7 region", int'(pix_region), reg_e);
            check("R8 R9 vphase", int'({v1, v2, v3}), exp_vph(m_h, m_v, m_dbl));
            check("R9 sg", int'(sg), int'(m_v == 0 && m_h >= SGS + SGP && m_h < SGS + SGP + SGL));
            check("R10 sub", int'(sub_pulse),
                  int'(m_v >= 1 && m_v < m_shut && m_h >= SUBS && m_h < SUBS + SUBP));
        end
    end

    task automatic wait_vd_rise();
        bit pv;
        pv = vd;
        forever begin
            @(posedge clk); #1;
            if (vd && !pv) break;
            pv = vd;
        end
    endtask

    task automatic finish_run();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R11: state right after the reset edge
        check("R11 vd after reset", int'(vd), 1);
        check("R11 hd after reset", int'(hd), 1);
        rst = 1'b0;
        begin
            int t0;
            wait_vd_rise();
            t0 = cyc;
            wait_vd_rise();
            check("R2 normal frame length", cyc - t0, LN * LP * 4);
            // R3: mid-frame change must not shorten the running frame
            t0 = cyc;
            repeat (700) @(negedge clk);
            dbl_mode = 1'b1; shut_line = LW'(5);
            wait_vd_rise();
            check("R3 frame kept after mid-frame change", cyc - t0, LN * LP * 4);
            t0 = cyc;
            wait_vd_rise();
            check("R2 double frame length", cyc - t0, LD * LP * 4);
            @(negedge clk); shut_line = LW'(LN);
            wait_vd_rise(); wait_vd_rise();
            @(negedge clk); dbl_mode = 1'b0; shut_line = LW'(1);
            wait_vd_rise(); wait_vd_rise();
            @(negedge clk); shut_line = LW'(9);
            wait_vd_rise();
            repeat (900) @(negedge clk);
            // R11: mid-frame reset
            rst = 1'b1;
            @(negedge clk);
            check("R11 vd after mid reset", int'(vd), 1);
            check("R11 hd after mid reset", int'(hd), 1);
            rst = 1'b0;
            t0 = cyc;
            wait_vd_rise();
            check("R2 frame after reset", cyc - t0, LN * LP * 4);
            wait_vd_rise();
        end
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        finish_run();
    end
endmodule